// File: doc/BRIEF.md
# Transaction-Aware Divergence Stack

This block keeps the control-flow state of one warp of lockstep lanes. A stack of typed entries records where each group of lanes resumes and where it joins the others again. The top entry supplies the warp's current program counter and its lane mask. When a branch splits the lanes, the taken group and the not-taken group each get their own entry, and both share one join address. When the running group reaches its join address it is popped, and the entry below takes over.

On top of this, transactional regions behave like a loop that runs again only for the lanes that failed. Starting a transaction places two entries. The lower one is a retry collector with an empty mask. The upper one is a transaction marker that holds the lanes which entered. At the commit point, the validation logic supplies the lanes whose transaction failed. Those lanes are gathered into the collector. If any lane failed, the warp jumps back to the start of the transaction with only those lanes active. If no lane failed, both entries are removed and the warp continues after the commit with the mask it had before the transaction.

The block has one command port. Each cycle it accepts one command together with its PC and mask operands. It does not fetch instructions and it does not validate transactions. When a push would exceed the stack depth, the block raises a sticky overflow flag.

Top module: `simt_txn_stack`

## Requirements
- R1: While reset is high and in the first cycle after it, the stack holds a single normal base entry: cur_pc = RESET_PC (0), cur_mask = all ones, overflow = 0. Mask bit i is lane i.
- R2: Command code 1 (advance) sets cur_pc to op_pc one cycle later and leaves cur_mask unchanged, except for the case in R4.
- R3: Command code 2 (branch) with lane mask M on top, where both M&op_mask and M&~op_mask are nonzero, pushes two entries. One cycle later, cur_pc = op_pc and cur_mask = M&op_mask.
- R4: An advance whose op_pc equals the join PC (op_rpc of the branch) of a normal top entry that is not the base pops that entry. First the not-taken path appears, at op_alt_pc with mask M&~op_mask. After it also reaches the join, the continuation appears at the join PC with mask M.
- R5: No path with an empty mask is ever executed. For a branch where all active lanes agree, nothing is pushed: cur_pc becomes op_pc if any active lane is taken, otherwise op_alt_pc, and cur_mask is unchanged.
- R6: Command code 3 (transaction begin) pushes a retry entry (PC = op_pc, empty mask) and a transaction entry that carries the current mask. One cycle later, cur_pc = op_pc.
- R7: Command code 4 (commit) on a transaction entry computes F = op_mask & cur_mask, the failed lanes. If F is nonzero, the next cycle has cur_pc = the transaction start PC and cur_mask = F. If F is zero, both entries pop and the warp resumes at op_pc with the mask from before the transaction.
- R8: A divergent branch inside a transaction pushes normal entries above the transaction entry. After both paths reach the join, the transaction entry is on top again with its full mask.
- R9: A push that would take the stack beyond DEPTH entries leaves cur_pc and cur_mask unchanged and sets overflow. overflow stays at 1 until reset.
- R10: A commit while the top entry is not a transaction entry has no effect on cur_pc or cur_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | 0 idle, 1 advance, 2 branch, 3 transaction begin, 4 commit |
| op_pc | input | PC_W | Advance target, taken target, transaction start, or PC after commit |
| op_alt_pc | input | PC_W | Not-taken PC for a branch |
| op_rpc | input | PC_W | Join PC for a branch |
| op_mask | input | LANES | Taken lanes for a branch, failed lanes for a commit |
| cur_pc | output | PC_W | PC of the top entry |
| cur_mask | output | LANES | Active lanes of the top entry |
| overflow | output | 1 | Sticky flag for a refused push |

## Verification
Branches are driven with four kinds of taken mask:
- A split mask, which separates the path that runs first from the path that waits.
- An all-taken mask and an all-not-taken mask, which show that uniform branches push nothing.
- A taken mask whose only bits are inactive lanes, which shows that inactive lanes are disregarded.

Commit failure masks are driven in four ways:
- A partial failure.
- A smaller failure on the retry pass, which separates lane accumulation from restart.
- Failures that only touch lanes already committed, which must count as success.
- An empty failure mask, which must pop both entries.

A run of nested transaction begins fills the stack to the refusal point, so the overflow behaviour can be told apart from an ordinary push.

// File: rtl/simt_txs_pkg.sv
package simt_txs_pkg;
  typedef enum logic [1:0] {
    KIND_N = 2'd0,
    KIND_R = 2'd1,
    KIND_T = 2'd2
  } kind_e;

  localparam logic [2:0] OP_IDLE = 3'd0;
  localparam logic [2:0] OP_ADV  = 3'd1;
  localparam logic [2:0] OP_BR   = 3'd2;
  localparam logic [2:0] OP_TXB  = 3'd3;
  localparam logic [2:0] OP_CMT  = 3'd4;
endpackage

// File: rtl/simt_entry_store.sv
module simt_entry_store #(
  parameter int W  = 38,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we0,
  input  logic [IW-1:0] wa0,
  input  logic [W-1:0]  wd0,
  input  logic          we1,
  input  logic [IW-1:0] wa1,
  input  logic [W-1:0]  wd1,
  input  logic [IW-1:0] ra0,
  input  logic [IW-1:0] ra1,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1
);
  localparam int NSLOT = 1 << IW;

  logic [W-1:0] mem [NSLOT];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];

  // two pushes in one cycle always target neighbouring slots
  AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (rst)
    (we0 && we1) |-> (wa0 != wa1)); // R3
endmodule

// File: rtl/simt_path_split.sv
module simt_path_split #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] active,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] tk_mask,
  output logic [LANES-1:0] nt_mask,
  output logic             tk_live,
  output logic             nt_live
);
  assign tk_mask = active & taken;
  assign nt_mask = active & ~taken;
  assign tk_live = |tk_mask;
  assign nt_live = |nt_mask;
endmodule

// File: rtl/simt_txn_stack.sv
module simt_txn_stack
  import simt_txs_pkg::*;
#(
  parameter int              LANES    = 4,
  parameter int              PC_W     = 16,
  parameter int              DEPTH    = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_code,
  input  logic [PC_W-1:0]  op_pc,
  input  logic [PC_W-1:0]  op_alt_pc,
  input  logic [PC_W-1:0]  op_rpc,
  input  logic [LANES-1:0] op_mask,
  output logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] cur_mask,
  output logic             overflow
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int SLOTS = DEPTH - 1;
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int ENT_W = 2 + 2 * PC_W + LANES;

  kind_e            top_kind, n_kind;
  logic [PC_W-1:0]  top_pc, n_pc, top_rpc, n_rpc;
  logic [LANES-1:0] top_mask, n_mask;
  logic [CW-1:0]    cnt, n_cnt;
  logic             ovf_q, n_ovf;

  logic [CW-1:0]    cnt_m1, cnt_m2, cnt_m3;
  logic             we0, we1;
  logic [IW-1:0]    wa0, wa1;
  logic [ENT_W-1:0] wd0, wd1, rd0, rd1, top_word;

  kind_e            b1_kind, b2_kind;
  logic [PC_W-1:0]  b1_pc, b1_rpc, b2_rpc;
  logic [LANES-1:0] b1_mask, b2_mask;
  logic [LANES-1:0] tk_mask, nt_mask, fail, rsum;
  logic             tk_live, nt_live, room2, is_txn;

  assign cnt_m1   = cnt - CW'(1);
  assign cnt_m2   = cnt - CW'(2);
  assign cnt_m3   = cnt - CW'(3);
  assign top_word = {top_kind, top_pc, top_rpc, top_mask};
  assign room2    = (cnt <= CW'(DEPTH - 2));
  assign is_txn   = (top_kind == KIND_T) && (cnt >= CW'(3));

  simt_entry_store #(.W(ENT_W), .IW(IW)) u_store (
    .clk (clk), .rst (rst),
    .we0 (we0), .wa0 (wa0), .wd0 (wd0),
    .we1 (we1), .wa1 (wa1), .wd1 (wd1),
    .ra0 (cnt_m2[IW-1:0]), .ra1 (cnt_m3[IW-1:0]),
    .rd0 (rd0), .rd1 (rd1)
  );

  simt_path_split #(.LANES(LANES)) u_split (
    .active (top_mask), .taken (op_mask),
    .tk_mask (tk_mask), .nt_mask (nt_mask),
    .tk_live (tk_live), .nt_live (nt_live)
  );

  assign b1_kind = kind_e'(rd0[ENT_W-1 -: 2]);
  assign b1_pc   = rd0[ENT_W-3 -: PC_W];
  assign b1_rpc  = rd0[LANES+PC_W-1 -: PC_W];
  assign b1_mask = rd0[LANES-1:0];
  assign b2_kind = kind_e'(rd1[ENT_W-1 -: 2]);
  assign b2_rpc  = rd1[LANES+PC_W-1 -: PC_W];
  assign b2_mask = rd1[LANES-1:0];

  assign fail = op_mask & top_mask;
  assign rsum = b1_mask | fail;

  always_comb begin
    n_kind = top_kind;
    n_pc   = top_pc;
    n_rpc  = top_rpc;
    n_mask = top_mask;
    n_cnt  = cnt;
    n_ovf  = ovf_q;
    we0    = 1'b0;
    we1    = 1'b0;
    wa0    = cnt_m1[IW-1:0];
    wa1    = cnt[IW-1:0];
    wd0    = top_word;
    wd1    = '0;
    case (op_code)
      OP_ADV: begin
        if (top_kind == KIND_N && cnt > CW'(1) && op_pc == top_rpc) begin
          n_kind = b1_kind;
          n_pc   = b1_pc;
          n_rpc  = b1_rpc;
          n_mask = b1_mask;
          n_cnt  = cnt_m1;
        end else begin
          n_pc = op_pc;
        end
      end
      OP_BR: begin
        if (tk_live && nt_live) begin
          if (!room2) begin
            n_ovf = 1'b1;
          end else begin
            we0    = 1'b1;
            wd0    = {top_kind, op_rpc, top_rpc, top_mask};
            we1    = 1'b1;
            wd1    = {KIND_N, op_alt_pc, op_rpc, nt_mask};
            n_kind = KIND_N;
            n_pc   = op_pc;
            n_rpc  = op_rpc;
            n_mask = tk_mask;
            n_cnt  = cnt + CW'(2);
          end
        end else if (tk_live) begin
          n_pc = op_pc;
        end else begin
          n_pc = op_alt_pc;
        end
      end
      OP_TXB: begin
        if (!room2) begin
          n_ovf = 1'b1;
        end else begin
          we0    = 1'b1;
          we1    = 1'b1;
          wd1    = {KIND_R, op_pc, op_pc, {LANES{1'b0}}};
          n_kind = KIND_T;
          n_pc   = op_pc;
          n_rpc  = op_pc;
          n_cnt  = cnt + CW'(2);
        end
      end
      OP_CMT: begin
        if (is_txn) begin
          if (|rsum) begin
            we0    = 1'b1;
            wa0    = cnt_m2[IW-1:0];
            wd0    = {KIND_R, b1_pc, b1_rpc, {LANES{1'b0}}};
            n_pc   = b1_pc;
            n_mask = rsum;
          end else begin
            n_kind = b2_kind;
            n_pc   = op_pc;
            n_rpc  = b2_rpc;
            n_mask = b2_mask;
            n_cnt  = cnt_m2;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_kind <= KIND_N;
      top_pc   <= RESET_PC;
      top_rpc  <= '1;
      top_mask <= '1;
      cnt      <= CW'(1);
      ovf_q    <= 1'b0;
    end else begin
      top_kind <= n_kind;
      top_pc   <= n_pc;
      top_rpc  <= n_rpc;
      top_mask <= n_mask;
      cnt      <= n_cnt;
      ovf_q    <= n_ovf;
    end
  end

  assign cur_pc   = top_pc;
  assign cur_mask = top_mask;
  assign overflow = ovf_q;

  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) && (cnt <= CW'(DEPTH))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q); // R9
  AST_BASE_FULL: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(1)) |-> (top_kind == KIND_N && top_mask == '1)); // R4
  AST_NO_EMPTY_PATH: assert property (@(posedge clk) disable iff (rst)
    top_mask != '0); // R5
  AST_RETRY_STAYS_TXN: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_CMT && is_txn && (op_mask & top_mask) != '0)
    |=> (top_kind == KIND_T && $stable(cnt))); // R7
  AST_CMT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_CMT && top_kind != KIND_T)
    |=> ($stable(top_pc) && $stable(top_mask))); // R10
endmodule

// File: tb/test_simt_txn_stack.sv
`timescale 1ns/1ps
module test_simt_txn_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_code = 3'd0;
  logic [15:0] op_pc = '0, op_alt_pc = '0, op_rpc = '0;
  logic [3:0]  op_mask = '0;
  logic [15:0] cur_pc;
  logic [3:0]  cur_mask;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] q_pc[$];
  logic [3:0]  q_mask[$];
  logic        q_ovf[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  simt_txn_stack #(.LANES(4), .PC_W(16), .DEPTH(16)) i_simt_txn_stack (
    .clk(clk), .rst(rst), .op_code(op_code), .op_pc(op_pc),
    .op_alt_pc(op_alt_pc), .op_rpc(op_rpc), .op_mask(op_mask),
    .cur_pc(cur_pc), .cur_mask(cur_mask), .overflow(overflow)
  );

  task automatic compare(input logic [15:0] e_pc, input logic [3:0] e_mask,
                         input logic e_ovf, input string tag);
    checks++;
    if (cur_pc !== e_pc || cur_mask !== e_mask || overflow !== e_ovf) begin
      errors++;
      $display("FAIL %s: pc=%0d mask=%b ovf=%b, expected pc=%0d mask=%b ovf=%b",
               tag, cur_pc, cur_mask, overflow, e_pc, e_mask, e_ovf);
    end
  endtask

  // driver: one command per cycle, expectation queued for the monitor
  task automatic do_op(input logic [2:0] op, input logic [15:0] pc,
                       input logic [15:0] alt, input logic [15:0] rpc,
                       input logic [3:0] msk, input logic [15:0] e_pc,
                       input logic [3:0] e_mask, input logic e_ovf,
                       input string tag);
    @(negedge clk);
    op_code = op; op_pc = pc; op_alt_pc = alt; op_rpc = rpc; op_mask = msk;
    q_pc.push_back(e_pc);
    q_mask.push_back(e_mask);
    q_ovf.push_back(e_ovf);
    q_tag.push_back(tag);
  endtask

  // monitor: result of the command registered at this edge
  always @(posedge clk) begin
    #2;
    if (q_pc.size() > 0) begin
      compare(q_pc.pop_front(), q_mask.pop_front(), q_ovf.pop_front(),
              q_tag.pop_front());
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(16'd0, 4'b1111, 1'b0, "R1 reset state");
    rst = 1'b0;
    @(posedge clk); #2;
    compare(16'd0, 4'b1111, 1'b0, "R1 first cycle after reset");

    do_op(3'd1, 16'd1,   0, 0, 4'b0000, 16'd1,   4'b1111, 0, "R2 advance");
    do_op(3'd2, 16'd10,  16'd2, 16'd20, 4'b0011, 16'd10, 4'b0011, 0, "R3 split branch taken path");
    do_op(3'd1, 16'd11,  0, 0, 4'b0000, 16'd11,  4'b0011, 0, "R2 advance on taken path");
    do_op(3'd1, 16'd20,  0, 0, 4'b0000, 16'd2,   4'b1100, 0, "R4 pop to not-taken path");
    do_op(3'd1, 16'd20,  0, 0, 4'b0000, 16'd20,  4'b1111, 0, "R4 pop to continuation");
    do_op(3'd2, 16'd30,  16'd21, 16'd40, 4'b1111, 16'd30, 4'b1111, 0, "R5 all-taken branch");
    do_op(3'd2, 16'd50,  16'd31, 16'd40, 4'b0000, 16'd31, 4'b1111, 0, "R5 none-taken branch");
    do_op(3'd1, 16'd40,  0, 0, 4'b0000, 16'd40,  4'b1111, 0, "R4 base entry never pops");
    do_op(3'd3, 16'd100, 0, 0, 4'b0000, 16'd100, 4'b1111, 0, "R6 transaction begin");
    do_op(3'd2, 16'd110, 16'd101, 16'd120, 4'b0101, 16'd110, 4'b0101, 0, "R8 branch inside transaction");
    do_op(3'd1, 16'd120, 0, 0, 4'b0000, 16'd101, 4'b1010, 0, "R8 not-taken path inside transaction");
    do_op(3'd1, 16'd120, 0, 0, 4'b0000, 16'd120, 4'b1111, 0, "R8 transaction entry back on top");
    do_op(3'd4, 16'd130, 0, 0, 4'b1100, 16'd100, 4'b1100, 0, "R7 partial failure restarts");
    do_op(3'd1, 16'd105, 0, 0, 4'b0000, 16'd105, 4'b1100, 0, "R2 advance in retry");
    do_op(3'd2, 16'd150, 16'd106, 16'd107, 4'b0011, 16'd106, 4'b1100, 0, "R5 taken bits only on inactive lanes");
    do_op(3'd4, 16'd130, 0, 0, 4'b0100, 16'd100, 4'b0100, 0, "R7 second failure narrows retry");
    do_op(3'd4, 16'd130, 0, 0, 4'b0000, 16'd130, 4'b1111, 0, "R7 all committed resumes");
    do_op(3'd4, 16'd999, 0, 0, 4'b1111, 16'd130, 4'b1111, 0, "R10 commit on normal entry ignored");
    do_op(3'd3, 16'd200, 0, 0, 4'b0000, 16'd200, 4'b1111, 0, "R6 second transaction");
    do_op(3'd4, 16'd210, 0, 0, 4'b1010, 16'd200, 4'b1010, 0, "R7 failure restarts");
    do_op(3'd4, 16'd210, 0, 0, 4'b0101, 16'd210, 4'b1111, 0, "R7 failures on committed lanes disregarded");
    for (int k = 0; k < 7; k++) begin
      do_op(3'd3, 16'(300 + k), 0, 0, 4'b0000, 16'(300 + k), 4'b1111, 0, "R6 nested begin");
    end
    do_op(3'd3, 16'd307, 0, 0, 4'b0000, 16'd306, 4'b1111, 1, "R9 begin refused when full");
    do_op(3'd0, 16'd0,   0, 0, 4'b0000, 16'd306, 4'b1111, 1, "R9 flag sticky while idle");
    do_op(3'd2, 16'd320, 16'd321, 16'd330, 4'b0011, 16'd306, 4'b1111, 1, "R9 split branch refused when full");
    do_op(3'd2, 16'd350, 16'd351, 16'd360, 4'b1111, 16'd350, 4'b1111, 1, "R5 uniform branch still works when full");
    do_op(3'd4, 16'd400, 0, 0, 4'b0000, 16'd400, 4'b1111, 1, "R7 commit pops to enclosing transaction");
    do_op(3'd0, 16'd0,   0, 0, 4'b0000, 16'd400, 4'b1111, 1, "R9 flag held");
    @(negedge clk);
    op_code = 3'd0;
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule